// File: doc/BRIEF.md
# NAND Page Layout Reorder Address Generator

This unit produces the byte address pairs for a buffer-to-buffer copy that converts a NAND page between two arrangements. The first is the interleaved arrangement used on the medium with a BCH engine. There, each section holds its data bytes, then its free spare bytes, then a 32-byte ECC field, and this repeats for every section. An optional final section may have its own data and spare lengths. The second is the grouped arrangement seen by software: every data byte of the page first, then every spare byte, then every ECC field.

Software sets the layout on the configuration inputs and pulses `start` while the unit is idle. The unit latches the layout and the direction. It then walks the page in interleaved order, one byte per cycle, and presents a source address and a destination address for each byte. In the write direction it also marks the two padding bytes of each ECC field, so the copy engine writes 0xFF to those bytes instead of copying them. The BCH arithmetic and the flash bus are handled by other blocks.

The walk has three nested counters: section, region and byte. Each address is the base of its group plus the section index times the per-section length of that region. The layout must have at least one regular section or an enabled last section.

Top module: `nand_layout_reorder`

## Requirements
- R1: After reset, `out_valid`, `busy`, `done` and `pad_ff` are all low, and they stay low until `start` is seen.
- R2: A `start` pulse while idle raises `out_valid` on the next cycle. One address pair follows per cycle, with no gaps, for `N*(D+S+32) + (LD+LS+32 if the last section is enabled)` cycles. The first pair is (0, 0).
- R3: With `dir`=0 (read), `src_addr` steps through the interleaved offsets 0,1,2,… in order. `dst_addr` is the grouped offset of the same byte.
- R4: With `dir`=1 (write), `src_addr` is the grouped offset and `dst_addr` is the interleaved offset, which steps 0,1,2,… in order.
- R5: Grouped offsets: data byte b of section k is at k*D+b. Spare byte b is at TD+k*S+b. ECC byte b is at TD+TS+k*32+b. TD is the total of all data bytes and TS is the total of all spare bytes. Interleaved offsets: section k starts at k*(D+S+32), with data at offset 0, spare at offset D and ECC at offset D+S.
- R6: Every section has a 32-byte ECC field. `pad_ff` is high only for bytes 30 and 31 of each ECC field, and only in the write direction.
- R7: When `cfg_last_en`=1, a final section with index N uses `cfg_last_data_len` and `cfg_last_spare_len` for its data and spare lengths.
- R8: A spare length of zero, in the regular sections or in the last section, skips the spare region without adding a cycle.
- R9: While `busy` is high, `start`, `dir` and all configuration inputs are ignored. The running pass keeps the layout it latched.
- R10: `done` pulses for exactly one cycle, in the cycle after the last valid pair. In that cycle `busy` is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts one page pass when idle |
| dir | input | 1 | 0 = read (interleaved to grouped), 1 = write (grouped to interleaved) |
| cfg_sect_cnt | input | SECT_W | Number of regular sections N |
| cfg_data_len | input | DLEN_W | Data bytes per regular section D (512 to 2048) |
| cfg_spare_len | input | SLEN_W | Spare bytes per regular section S, may be 0 |
| cfg_last_en | input | 1 | Enables the extra final section |
| cfg_last_data_len | input | DLEN_W | Data bytes of the final section LD |
| cfg_last_spare_len | input | SLEN_W | Spare bytes of the final section LS, may be 0 |
| busy | output | 1 | A pass is running |
| out_valid | output | 1 | The address pair is valid this cycle |
| src_addr | output | ADDR_W | Source byte offset |
| dst_addr | output | ADDR_W | Destination byte offset |
| pad_ff | output | 1 | Write 0xFF at dst_addr instead of copying |
| done | output | 1 | One-cycle pulse after the final pair |

## Verification
The hardest case to reach is a zero-length spare region combined with a last section that has different lengths. The region transition must then skip straight from data to ECC, and the address arithmetic must move to the last section's lengths, both with no lost cycle. The stimulus runs passes with zero spare in the regular sections, with zero spare only in the last section, and with no regular sections at all. The bench then compares every cycle against a model that fills the grouped arrangement from three running pointers. A further pass changes every configuration input and pulses `start` in the middle of a walk, which shows whether the latched layout really holds.

// File: rtl/nrl_pkg.sv
package nrl_pkg;
    localparam int ECC_FIELD = 32;
    localparam int ECC_USED  = 30;

    typedef enum logic [1:0] {
        RG_DATA  = 2'd0,
        RG_SPARE = 2'd1,
        RG_ECC   = 2'd2
    } region_e;
endpackage

// File: rtl/nrl_walker.sv
module nrl_walker
    import nrl_pkg::*;
#(
    parameter int SECT_W = 4,
    parameter int DLEN_W = 12,
    parameter int SLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir,
    input  logic [SECT_W-1:0] cfg_sect_cnt,
    input  logic [DLEN_W-1:0] cfg_data_len,
    input  logic [SLEN_W-1:0] cfg_spare_len,
    input  logic              cfg_last_en,
    input  logic [DLEN_W-1:0] cfg_last_data_len,
    input  logic [SLEN_W-1:0] cfg_last_spare_len,
    output logic              busy,
    output logic              done,
    output logic              dir_o,
    output logic [SECT_W-1:0] sect_o,
    output region_e           region_o,
    output logic [DLEN_W-1:0] byte_o,
    output logic [SECT_W-1:0] n_o,
    output logic [DLEN_W-1:0] dlen_o,
    output logic [SLEN_W-1:0] slen_o,
    output logic              last_en_o,
    output logic [DLEN_W-1:0] ldlen_o,
    output logic [SLEN_W-1:0] lslen_o
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic              dir;
        logic [SECT_W-1:0] sect;
        region_e           region;
        logic [DLEN_W-1:0] byte_idx;
        logic [SECT_W-1:0] n;
        logic [DLEN_W-1:0] dlen;
        logic [SLEN_W-1:0] slen;
        logic              last_en;
        logic [DLEN_W-1:0] ldlen;
        logic [SLEN_W-1:0] lslen;
    } walk_t;

    walk_t st_d, st_q;

    function automatic region_e first_region(input logic [DLEN_W-1:0] dl,
                                             input logic [SLEN_W-1:0] sl);
        if (dl != '0)      return RG_DATA;
        else if (sl != '0) return RG_SPARE;
        else               return RG_ECC;
    endfunction

    logic              cur_is_last, nxt_is_last;
    logic [DLEN_W-1:0] cur_dlen, nxt_dlen, cur_len;
    logic [SLEN_W-1:0] cur_slen, nxt_slen;
    logic [SECT_W-1:0] final_sect;
    logic              at_end;

    always_comb begin
        cur_is_last = st_q.last_en && (st_q.sect == st_q.n);
        nxt_is_last = st_q.last_en && ((st_q.sect + SECT_W'(1)) == st_q.n);
        cur_dlen    = cur_is_last ? st_q.ldlen : st_q.dlen;
        cur_slen    = cur_is_last ? st_q.lslen : st_q.slen;
        nxt_dlen    = nxt_is_last ? st_q.ldlen : st_q.dlen;
        nxt_slen    = nxt_is_last ? st_q.lslen : st_q.slen;
        final_sect  = st_q.last_en ? st_q.n : (st_q.n - SECT_W'(1));
        case (st_q.region)
            RG_DATA:  cur_len = cur_dlen;
            RG_SPARE: cur_len = DLEN_W'(cur_slen);
            default:  cur_len = DLEN_W'(ECC_FIELD);
        endcase
        at_end = (st_q.byte_idx == (cur_len - DLEN_W'(1)));
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy     = 1'b1;
                st_d.dir      = dir;
                st_d.n        = cfg_sect_cnt;
                st_d.dlen     = cfg_data_len;
                st_d.slen     = cfg_spare_len;
                st_d.last_en  = cfg_last_en;
                st_d.ldlen    = cfg_last_data_len;
                st_d.lslen    = cfg_last_spare_len;
                st_d.sect     = '0;
                st_d.byte_idx = '0;
                if (cfg_last_en && (cfg_sect_cnt == '0))
                    st_d.region = first_region(cfg_last_data_len, cfg_last_spare_len);
                else
                    st_d.region = first_region(cfg_data_len, cfg_spare_len);
            end
        end else if (at_end) begin
            st_d.byte_idx = '0;
            case (st_q.region)
                RG_DATA:  st_d.region = (cur_slen != '0) ? RG_SPARE : RG_ECC;
                RG_SPARE: st_d.region = RG_ECC;
                default: begin
                    if (st_q.sect == final_sect) begin
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.sect   = st_q.sect + SECT_W'(1);
                        st_d.region = first_region(nxt_dlen, nxt_slen);
                    end
                end
            endcase
        end else begin
            st_d.byte_idx = st_q.byte_idx + DLEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.region <= RG_DATA;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign dir_o     = st_q.dir;
    assign sect_o    = st_q.sect;
    assign region_o  = st_q.region;
    assign byte_o    = st_q.byte_idx;
    assign n_o       = st_q.n;
    assign dlen_o    = st_q.dlen;
    assign slen_o    = st_q.slen;
    assign last_en_o = st_q.last_en;
    assign ldlen_o   = st_q.ldlen;
    assign lslen_o   = st_q.lslen;

    // R10: done follows the final busy cycle and never overlaps busy
    a_r10_done_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (!st_q.busy && $past(st_q.busy)));

    // R9: latched layout holds for the whole pass
    a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |->
            ($stable(st_q.n) && $stable(st_q.dlen) && $stable(st_q.slen) &&
             $stable(st_q.last_en) && $stable(st_q.ldlen) &&
             $stable(st_q.lslen) && $stable(st_q.dir)));

    // R8: the walker never sits in an empty region
    a_r8_byte_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.byte_idx < cur_len));
endmodule

// File: rtl/nrl_addr_map.sv
module nrl_addr_map
    import nrl_pkg::*;
#(
    parameter int SECT_W = 4,
    parameter int DLEN_W = 12,
    parameter int SLEN_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              dir,
    input  logic [SECT_W-1:0] n,
    input  logic [DLEN_W-1:0] dlen,
    input  logic [SLEN_W-1:0] slen,
    input  logic              last_en,
    input  logic [DLEN_W-1:0] ldlen,
    input  logic [SLEN_W-1:0] lslen,
    input  logic [SECT_W-1:0] sect,
    input  region_e           region,
    input  logic [DLEN_W-1:0] byte_idx,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              pad
);
    logic              is_last;
    logic [ADDR_W-1:0] tot_data, tot_spare, pitch, sect_a, byte_a;
    logic [ADDR_W-1:0] cur_d, cur_s, ilv_addr, grp_addr;

    always_comb begin
        is_last   = last_en && (sect == n);
        sect_a    = ADDR_W'(sect);
        byte_a    = ADDR_W'(byte_idx);
        cur_d     = is_last ? ADDR_W'(ldlen) : ADDR_W'(dlen);
        cur_s     = is_last ? ADDR_W'(lslen) : ADDR_W'(slen);
        tot_data  = ADDR_W'(n) * ADDR_W'(dlen)  + (last_en ? ADDR_W'(ldlen) : '0);
        tot_spare = ADDR_W'(n) * ADDR_W'(slen)  + (last_en ? ADDR_W'(lslen) : '0);
        pitch     = ADDR_W'(dlen) + ADDR_W'(slen) + ADDR_W'(ECC_FIELD);
        case (region)
            RG_DATA: begin
                ilv_addr = sect_a * pitch + byte_a;
                grp_addr = sect_a * ADDR_W'(dlen) + byte_a;
            end
            RG_SPARE: begin
                ilv_addr = sect_a * pitch + cur_d + byte_a;
                grp_addr = tot_data + sect_a * ADDR_W'(slen) + byte_a;
            end
            default: begin
                ilv_addr = sect_a * pitch + cur_d + cur_s + byte_a;
                grp_addr = tot_data + tot_spare + sect_a * ADDR_W'(ECC_FIELD) + byte_a;
            end
        endcase
        src_addr = dir ? grp_addr : ilv_addr;
        dst_addr = dir ? ilv_addr : grp_addr;
        pad      = dir && (region == RG_ECC) && (byte_idx >= DLEN_W'(ECC_USED));
    end
endmodule

// File: rtl/nand_layout_reorder.sv
module nand_layout_reorder
    import nrl_pkg::*;
#(
    parameter int SECT_W = 4,
    parameter int DLEN_W = 12,
    parameter int SLEN_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir,
    input  logic [SECT_W-1:0] cfg_sect_cnt,
    input  logic [DLEN_W-1:0] cfg_data_len,
    input  logic [SLEN_W-1:0] cfg_spare_len,
    input  logic              cfg_last_en,
    input  logic [DLEN_W-1:0] cfg_last_data_len,
    input  logic [SLEN_W-1:0] cfg_last_spare_len,
    output logic              busy,
    output logic              out_valid,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              pad_ff,
    output logic              done
);
    logic              w_dir, w_last_en, map_pad;
    logic [SECT_W-1:0] w_sect, w_n;
    region_e           w_region;
    logic [DLEN_W-1:0] w_byte, w_dlen, w_ldlen;
    logic [SLEN_W-1:0] w_slen, w_lslen;

    nrl_walker #(.SECT_W(SECT_W), .DLEN_W(DLEN_W), .SLEN_W(SLEN_W)) walker_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir),
        .cfg_sect_cnt(cfg_sect_cnt), .cfg_data_len(cfg_data_len),
        .cfg_spare_len(cfg_spare_len), .cfg_last_en(cfg_last_en),
        .cfg_last_data_len(cfg_last_data_len), .cfg_last_spare_len(cfg_last_spare_len),
        .busy(busy), .done(done), .dir_o(w_dir), .sect_o(w_sect),
        .region_o(w_region), .byte_o(w_byte), .n_o(w_n), .dlen_o(w_dlen),
        .slen_o(w_slen), .last_en_o(w_last_en), .ldlen_o(w_ldlen), .lslen_o(w_lslen)
    );

    nrl_addr_map #(.SECT_W(SECT_W), .DLEN_W(DLEN_W), .SLEN_W(SLEN_W), .ADDR_W(ADDR_W)) map_i (
        .dir(w_dir), .n(w_n), .dlen(w_dlen), .slen(w_slen), .last_en(w_last_en),
        .ldlen(w_ldlen), .lslen(w_lslen), .sect(w_sect), .region(w_region),
        .byte_idx(w_byte), .src_addr(src_addr), .dst_addr(dst_addr), .pad(map_pad)
    );

    assign out_valid = busy;
    assign pad_ff    = busy && map_pad;

    logic [ADDR_W-1:0] ilv_side;
    assign ilv_side = w_dir ? dst_addr : src_addr;

    // R3 / R4: the interleaved side advances by one on every consecutive valid cycle
    a_r3_ilv_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (ilv_side == $past(ilv_side) + ADDR_W'(1)));

    // R2: every pass opens at offset zero on both sides
    a_r2_first_pair_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (src_addr == '0 && dst_addr == '0));

    // R6: padding marks appear only in write passes
    a_r6_pad_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        pad_ff |-> (out_valid && w_dir));
endmodule

// File: tb/nand_layout_reorder_tb_top.sv
module nand_layout_reorder_tb_top;
    localparam int SECT_W = 4, DLEN_W = 12, SLEN_W = 8, ADDR_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, dir = 1'b0, cfg_last_en = 1'b0;
    logic [SECT_W-1:0] cfg_sect_cnt = '0;
    logic [DLEN_W-1:0] cfg_data_len = '0, cfg_last_data_len = '0;
    logic [SLEN_W-1:0] cfg_spare_len = '0, cfg_last_spare_len = '0;
    logic busy, out_valid, pad_ff, done;
    logic [ADDR_W-1:0] src_addr, dst_addr;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    nand_layout_reorder #(.SECT_W(SECT_W), .DLEN_W(DLEN_W), .SLEN_W(SLEN_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir),
        .cfg_sect_cnt(cfg_sect_cnt), .cfg_data_len(cfg_data_len),
        .cfg_spare_len(cfg_spare_len), .cfg_last_en(cfg_last_en),
        .cfg_last_data_len(cfg_last_data_len), .cfg_last_spare_len(cfg_last_spare_len),
        .busy(busy), .out_valid(out_valid), .src_addr(src_addr), .dst_addr(dst_addr),
        .pad_ff(pad_ff), .done(done)
    );

    task automatic check(input bit ok, input string req, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic run_pass(input bit wr, input int n, input int d, input int s,
                            input bit le, input int ld, input int ls, input bit disturb);
        int q_src[$], q_dst[$];
        bit q_pad[$];
        string q_tag[$];
        int td, ts, dp, sp, ep, ilv, nsec;
        td = n * d + (le ? ld : 0);
        ts = n * s + (le ? ls : 0);
        dp = 0; sp = td; ep = td + ts; ilv = 0;
        nsec = n + (le ? 1 : 0);
        for (int k = 0; k < nsec; k++) begin
            bit lastsec;
            int dl, sl;
            string tg;
            lastsec = le && (k == n);
            dl = lastsec ? ld : d;
            sl = lastsec ? ls : s;
            for (int r = 0; r < 3; r++) begin
                int len, gp;
                len = (r == 0) ? dl : (r == 1) ? sl : 32;
                for (int b = 0; b < len; b++) begin
                    gp = (r == 0) ? dp : (r == 1) ? sp : ep;
                    if (lastsec)      tg = "R7";
                    else if (sl == 0) tg = "R8";
                    else if (r == 1)  tg = "R5";
                    else if (r == 2)  tg = "R6";
                    else              tg = wr ? "R4" : "R3";
                    q_src.push_back(wr ? gp : ilv);
                    q_dst.push_back(wr ? ilv : gp);
                    q_pad.push_back(wr && (r == 2) && (b >= 30));
                    q_tag.push_back(tg);
                    ilv++;
                    if (r == 0) dp++; else if (r == 1) sp++; else ep++;
                end
            end
        end

        @(negedge clk);
        dir = wr; cfg_sect_cnt = SECT_W'(n); cfg_data_len = DLEN_W'(d);
        cfg_spare_len = SLEN_W'(s); cfg_last_en = le;
        cfg_last_data_len = DLEN_W'(ld); cfg_last_spare_len = SLEN_W'(ls);
        start = 1'b1;
        for (int i = 0; i < q_src.size(); i++) begin
            @(negedge clk);
            if (i == 0) start = 1'b0;
            check(out_valid && busy && src_addr == ADDR_W'(q_src[i]) &&
                  dst_addr == ADDR_W'(q_dst[i]) && pad_ff == q_pad[i] && !done,
                  (i == 0) ? "R2" : (disturb && i > 3) ? "R9" : q_tag[i],
                  $sformatf("v=%0b src=%0d dst=%0d pad=%0b", out_valid, src_addr, dst_addr, pad_ff),
                  $sformatf("v=1 src=%0d dst=%0d pad=%0b", q_src[i], q_dst[i], q_pad[i]));
            if (disturb && i == 3) begin
                start = 1'b1; dir = ~wr; cfg_sect_cnt = SECT_W'(7);
                cfg_data_len = DLEN_W'(777); cfg_spare_len = SLEN_W'(3);
                cfg_last_en = ~le; cfg_last_data_len = DLEN_W'(9); cfg_last_spare_len = SLEN_W'(1);
            end
            if (disturb && i == 4) start = 1'b0;
        end
        @(negedge clk);
        check(done && !busy && !out_valid && !pad_ff, "R10",
              $sformatf("done=%0b busy=%0b v=%0b", done, busy, out_valid), "done=1 busy=0 v=0");
        @(negedge clk);
        check(!done && !busy, "R10", $sformatf("done=%0b busy=%0b", done, busy), "done=0 busy=0");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !out_valid && !done && !pad_ff, "R1",
              $sformatf("busy=%0b v=%0b done=%0b", busy, out_valid, done), "all 0");
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(!busy && !out_valid && !done && !pad_ff, "R1",
                  $sformatf("busy=%0b v=%0b done=%0b", busy, out_valid, done), "all 0");
        end
        run_pass(0, 2, 512, 8, 0, 0, 0, 0);      // R3, R5
        run_pass(1, 2, 512, 8, 0, 0, 0, 0);      // R4, R6
        run_pass(0, 3, 1024, 0, 1, 200, 0, 0);   // R8 with a last section, R7
        run_pass(1, 1, 512, 16, 1, 64, 5, 1);    // R9 disturbance, R7
        run_pass(1, 4, 2048, 32, 0, 0, 0, 0);    // R4, R6 at the largest chunk
        run_pass(0, 0, 0, 0, 1, 300, 4, 0);      // R7 last section only
        run_pass(1, 2, 600, 12, 1, 100, 0, 0);   // R8 zero spare in last section only
        repeat (3) begin
            @(negedge clk);
            check(!busy && !out_valid && !done, "R1",
                  $sformatf("busy=%0b v=%0b", busy, out_valid), "idle");
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule